// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block moves 8-bit frames over a three-wire clocked serial link and acts as the clock master. A byte written to its transmit input is shifted out on the data-out pin while a byte arrives on the data-in pin under the same transfer clock. When the frame completes, the received byte is presented with a one-cycle valid strobe.

An 8-bit control register configures the port. It selects which divided system clock feeds the baud counter, which transfer clock edge launches data and which one samples it, and the bit order. It also selects a push-pull or open-drain data output and the role of the handshake pins. In one role the handshake gates the start of transmission; in the other it tells the far end whether the receiver can take a byte. A second register holds the baud reload value. A read-only bit of the control register shows whether the transmitter is idle.

Top module: `csio_port`

## Requirements
- R1: After reset the control register (address 0) reads 0x08, the reload register (address 1) reads 0x00, `sclk` is 1, `sd_out` is 1, `sd_oe` is 1, `hs_out_n` is 1 and `rx_valid` is 0.
- R2: Control bits [1:0] select the count source: 00 is the system clock, 01 is the clock divided by 8 and 10 is the clock divided by 32. Within a frame, consecutive `sclk` edges are M×(N+1) clock cycles apart, where M is 1, 8 or 32 and N is the reload value.
- R3: Count source 11 is inhibited. No `sclk` edge occurs and a frame in progress stalls with the idle bit at 0. Selecting a valid source again lets the frame finish with correct data.
- R4: `sclk` idles at 1 and a frame has 16 edges. With control bit 4 at 0, data changes on falling edges and is sampled on rising edges. With bit 4 at 1, data changes on rising edges and is sampled on falling edges, and the first bit is already present before the first falling edge.
- R5: Control bit 2 sets the bit order: 0 sends and receives bit 0 first, and 1 sends and receives bit 7 first.
- R6: Control bit 3 is read-only. It reads 0 from a `tx_load` until that byte's frame has finished, and 1 when no byte is pending or shifting. Writes to it are ignored.
- R7: With control bit 7 = 0 and bit 6 = 0 (CTS role), a loaded byte starts shifting only while `hs_in_n` is 0. In this role `hs_out_n` stays 1.
- R8: With control bit 7 = 0 and bit 6 = 1 (RTS role), `hs_out_n` is 0 when no frame is active and no received byte is unread. It is 1 from the start of a frame until `rx_ack` is pulsed after the frame.
- R9: With control bit 7 = 1 the handshake is off: `hs_in_n` has no effect on starting a frame and `hs_out_n` stays 1.
- R10: Control bit 5 = 0 gives a push-pull output with `sd_oe` always 1. Bit 5 = 1 gives open-drain, where `sd_oe` is 1 exactly when `sd_out` is 0.
- R11: At the end of each frame `rx_valid` is high for one cycle and `rx_data` holds the byte received in the configured bit order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 reload |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Captures `tx_data` for the next frame |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| rx_ack | input | 1 | Marks the received byte as read |
| sclk | output | 1 | Transfer clock, idles high |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for the data-out pin |
| sd_in | input | 1 | Serial data in |
| hs_in_n | input | 1 | Handshake input, active low (CTS role) |
| hs_out_n | output | 1 | Handshake output, active low (RTS role) |

## Verification
The hardest case to reach is a frame frozen part way through by switching the count source to the inhibited code. The register write has to land between two transfer clock edges, and the frame must then recover without losing a bit. The bench does this from inside its slave model: after the fourth edge it issues the write, watches the pins for a fixed window, and restores the source. The bench then checks that the remaining edges finish the frame with both bytes intact. All combinations of edge polarity and bit order are also swept over several reload values and computed byte patterns.

// File: rtl/csio_pkg.sv
package csio_pkg;

    localparam int FRAME_BITS = 8;

    typedef enum logic [1:0] {
        SRC_FAST = 2'b00,
        SRC_MID  = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_OFF  = 2'b11
    } src_e;

    typedef struct packed {
        logic hs_off;
        logic hs_rts;
        logic od_mode;
        logic edge_pol;
        logic idle_ro;
        logic msb_first;
        src_e src;
    } ctl_t;

    function automatic logic src_valid(input src_e s);
        return s != SRC_OFF;
    endfunction

endpackage

// File: rtl/csio_baud.sv
module csio_baud
    import csio_pkg::*;
#(
    parameter int RELOAD_W = 8,
    parameter int DIV_MID  = 8,
    parameter int DIV_HIGH = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  src_e                src,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);
    localparam int MW = $clog2(DIV_MID);
    localparam int HW = $clog2(DIV_HIGH);
    localparam logic [MW-1:0] MID_LAST  = MW'(DIV_MID - 1);
    localparam logic [HW-1:0] HIGH_LAST = HW'(DIV_HIGH - 1);

    logic [MW-1:0]       mid_q;
    logic [HW-1:0]       high_q;
    logic [RELOAD_W-1:0] cnt_q;
    logic                src_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q  <= '0;
            high_q <= '0;
        end else begin
            mid_q  <= (mid_q == MID_LAST) ? '0 : mid_q + 1'b1;
            high_q <= (high_q == HIGH_LAST) ? '0 : high_q + 1'b1;
        end
    end

    always_comb begin
        case (src)
            SRC_FAST: src_en = 1'b1;
            SRC_MID:  src_en = (mid_q == MID_LAST);
            SRC_SLOW: src_en = (high_q == HIGH_LAST);
            default:  src_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= reload;
        end else if (src_en) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end

    assign tick = run && src_en && (cnt_q == '0);

endmodule

// File: rtl/csio_shift.sv
module csio_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] data,
    input  logic         msb_first,
    input  logic         pol,
    input  logic         tick,
    input  logic         sdi,
    output logic         busy,
    output logic         sclk,
    output logic         sdo,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int CW = $clog2(2 * W);
    localparam logic [CW-1:0] LAST = CW'(2 * W - 1);

    logic [CW-1:0] hc_q;
    logic [W-1:0]  tx_sr, rx_sr, ld_ord, rx_full, rx_ord;
    logic          pol_q, msb_q;

    always_comb begin
        rx_full = pol_q ? rx_sr : {sdi, rx_sr[W-1:1]};
        for (int i = 0; i < W; i++) begin
            ld_ord[i] = msb_first ? data[W-1-i] : data[i];
            rx_ord[i] = msb_q ? rx_full[W-1-i] : rx_full[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            hc_q    <= '0;
            sclk    <= 1'b1;
            sdo     <= 1'b1;
            tx_sr   <= '0;
            rx_sr   <= '0;
            pol_q   <= 1'b0;
            msb_q   <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                hc_q  <= '0;
                pol_q <= pol;
                msb_q <= msb_first;
                if (pol) begin
                    sdo   <= ld_ord[0];
                    tx_sr <= ld_ord >> 1;
                end else begin
                    tx_sr <= ld_ord;
                end
            end else if (busy && tick) begin
                sclk <= ~sclk;
                hc_q <= hc_q + 1'b1;
                if (!hc_q[0]) begin
                    if (!pol_q) begin
                        sdo   <= tx_sr[0];
                        tx_sr <= tx_sr >> 1;
                    end else begin
                        rx_sr <= {sdi, rx_sr[W-1:1]};
                    end
                end else begin
                    if (!pol_q) begin
                        rx_sr <= {sdi, rx_sr[W-1:1]};
                    end else if (hc_q != LAST) begin
                        sdo   <= tx_sr[0];
                        tx_sr <= tx_sr >> 1;
                    end
                end
                if (hc_q == LAST) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    rx_byte <= rx_ord;
                end
            end
        end
    end

endmodule

// File: rtl/csio_hs.sv
module csio_hs (
    input  logic hs_off,
    input  logic hs_rts,
    input  logic hs_in_n,
    input  logic busy,
    input  logic unread,
    output logic may_start,
    output logic hs_out_n
);
    always_comb begin
        may_start = hs_off || hs_rts || !hs_in_n;
        hs_out_n  = (hs_off || !hs_rts) ? 1'b1 : (busy || unread);
    end
endmodule

// File: rtl/csio_port.sv
module csio_port
    import csio_pkg::*;
#(
    parameter int DATA_W   = csio_pkg::FRAME_BITS,
    parameter int RELOAD_W = 8,
    parameter int DIV_MID  = 8,
    parameter int DIV_HIGH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ack,
    output logic              sclk,
    output logic              sd_out,
    output logic              sd_oe,
    input  logic              sd_in,
    input  logic              hs_in_n,
    output logic              hs_out_n
);
    ctl_t                ctl_q, ctl_wr, ctl_rd;
    logic [RELOAD_W-1:0] reload_q;
    logic [DATA_W-1:0]   hold_q;
    logic                pending_q, unread_q;
    logic                sh_busy, sh_done, sh_sdo, baud_tick, may_start, start;

    always_comb begin
        ctl_wr         = ctl_t'(reg_wdata);
        ctl_wr.idle_ro = 1'b0;
        ctl_rd         = ctl_q;
        ctl_rd.idle_ro = !sh_busy && !pending_q;
        reg_rdata      = reg_addr ? 8'(reload_q) : ctl_rd;
    end

    assign start = pending_q && may_start && !sh_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            reload_q  <= '0;
            hold_q    <= '0;
            pending_q <= 1'b0;
            unread_q  <= 1'b0;
        end else begin
            if (reg_we && !reg_addr) ctl_q    <= ctl_wr;
            if (reg_we && reg_addr)  reload_q <= RELOAD_W'(reg_wdata);
            if (start)   pending_q <= 1'b0;
            if (tx_load) begin
                hold_q    <= tx_data;
                pending_q <= 1'b1;
            end
            if (rx_ack)  unread_q <= 1'b0;
            if (sh_done) unread_q <= 1'b1;
        end
    end

    csio_baud #(
        .RELOAD_W(RELOAD_W), .DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)
    ) u_baud (
        .clk(clk), .rst(rst), .run(sh_busy), .src(ctl_q.src),
        .reload(reload_q), .tick(baud_tick)
    );

    csio_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .start(start), .data(hold_q),
        .msb_first(ctl_q.msb_first), .pol(ctl_q.edge_pol), .tick(baud_tick),
        .sdi(sd_in), .busy(sh_busy), .sclk(sclk), .sdo(sh_sdo),
        .done(sh_done), .rx_byte(rx_data)
    );

    csio_hs u_hs (
        .hs_off(ctl_q.hs_off), .hs_rts(ctl_q.hs_rts), .hs_in_n(hs_in_n),
        .busy(sh_busy), .unread(unread_q), .may_start(may_start),
        .hs_out_n(hs_out_n)
    );

    assign rx_valid = sh_done;
    assign sd_out   = sh_sdo;
    assign sd_oe    = ctl_q.od_mode ? !sh_sdo : 1'b1;

endmodule

// File: rtl/csio_port_chk.sv
module csio_port_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] ctl_bits,
    input logic       tick,
    input logic       busy,
    input logic       sclk,
    input logic       hs_in_n,
    input logic       hs_out_n,
    input logic       rx_valid,
    input logic       rx_ack
);
    a_r3_no_tick_inhibited: assert property (@(posedge clk) disable iff (rst)
        (ctl_bits[1:0] == 2'b11) |-> !tick);

    a_r4_sclk_moves_only_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sclk));

    a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sclk);

    a_r7_cts_gates_start: assert property (@(posedge clk) disable iff (rst)
        (!ctl_bits[7] && !ctl_bits[6] && $rose(busy)) |-> $past(!hs_in_n));

    a_r8_rts_held_after_frame: assert property (@(posedge clk) disable iff (rst)
        (!ctl_bits[7] && ctl_bits[6] && rx_valid && !rx_ack) |=> hs_out_n);

    a_r11_valid_single_cycle: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind csio_port csio_port_chk u_chk (
    .clk(clk), .rst(rst), .ctl_bits(ctl_q), .tick(baud_tick), .busy(sh_busy),
    .sclk(sclk), .hs_in_n(hs_in_n), .hs_out_n(hs_out_n),
    .rx_valid(rx_valid), .rx_ack(rx_ack)
);

// File: tb/csio_port_tb.sv
`timescale 1ns/1ps
module csio_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [7:0] tx_data = '0, rx_data;
    logic       tx_load = 1'b0, rx_valid, rx_ack = 1'b0;
    logic       sclk, sd_out, sd_oe, sd_in = 1'b1, hs_in_n = 1'b0, hs_out_n;
    int         checks = 0, fails = 0;
    bit         finished = 0;

    always #2.5 clk = ~clk;

    csio_port u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
        .tx_load(tx_load), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ack(rx_ack), .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe),
        .sd_in(sd_in), .hs_in_n(hs_in_n), .hs_out_n(hs_out_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); rx_ack = 1'b1;
        @(negedge clk); rx_ack = 1'b0;
    endtask

    function automatic int bi(input int i, input logic m);
        return m ? 7 - i : i;
    endfunction

    // Slave model: drives sd_in on the launch edges, captures the line on the sample edges.
    task automatic xfer(input logic [7:0] txb, input logic [7:0] slv, input logic [7:0] cv,
                        input int mult, input int n, input bit do_load, input bit stall);
        logic pol = cv[4], msb = cv[2], od = cv[5];
        bit   rts = !cv[7] && cv[6];
        bit   seen = 0, oe_ok = 1, hs_ok = 1, stall_ok = 1;
        int   edges = 0, sent = 0, got = 0, last = -1, cyc = 0;
        logic [7:0] cap = '0;
        logic prev, ln;
        sd_in = slv[bi(0, msb)];
        if (do_load) begin
            @(negedge clk); tx_data = txb; tx_load = 1'b1;
            @(negedge clk); tx_load = 1'b0;
        end
        prev = sclk;
        while (!seen && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            ln = sd_oe ? sd_out : 1'b1;
            if (od ? (sd_oe != !sd_out) : !sd_oe) oe_ok = 0;
            if (cv[7] && !hs_out_n) hs_ok = 0;
            if (sclk != prev) begin
                edges++;
                if (last >= 0) chk(cyc - last == mult * (n + 1), "R2 edge spacing", cyc - last, mult * (n + 1));
                last = cyc;
                if (!sclk) begin
                    if (!pol) begin if (sent < 8) sd_in = slv[bi(sent, msb)]; sent++; end
                    else begin if (got < 8) cap[bi(got, msb)] = ln; got++; end
                end else begin
                    if (!pol) begin if (got < 8) cap[bi(got, msb)] = ln; got++; end
                    else begin sent++; if (sent < 8) sd_in = slv[bi(sent, msb)]; end
                end
                prev = sclk;
                if (edges == 1) begin
                    chk(reg_rdata[3] == 1'b0, "R6 idle bit low in frame", reg_rdata[3], 0);
                    if (rts) chk(hs_out_n == 1'b1, "R8 rts high in frame", hs_out_n, 1);
                end
                if (stall && edges == 4) begin
                    wr(1'b0, cv | 8'h03);
                    for (int k = 0; k < 40; k++) begin
                        @(negedge clk);
                        if (sclk != prev) stall_ok = 0;
                    end
                    chk(stall_ok, "R3 no edge while inhibited", stall_ok, 1);
                    chk(reg_rdata[3] == 1'b0, "R3 frame still active", reg_rdata[3], 0);
                    wr(1'b0, cv);
                    last = -1;
                end
            end
            if (rx_valid) seen = 1;
        end
        chk(seen, "R11 valid strobe", seen, 1);
        chk(rx_data == slv, "R11 received byte", rx_data, slv);
        chk(cap == txb, "R5 transmitted byte order", cap, txb);
        chk(edges == 16, "R4 edges per frame", edges, 16);
        chk(oe_ok, "R10 output enable mode", oe_ok, 1);
        if (cv[7]) chk(hs_ok, "R9 handshake output off", hs_ok, 1);
        @(negedge clk);
        chk(rx_valid == 1'b0, "R11 valid one cycle", rx_valid, 0);
        chk(reg_rdata[3] == 1'b1, "R6 idle bit after frame", reg_rdata[3], 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 8'h08, "R1 control reset", reg_rdata, 8'h08);
        reg_addr = 1'b1; #1;
        chk(reg_rdata == 8'h00, "R1 reload reset", reg_rdata, 0);
        reg_addr = 1'b0;
        chk(sclk && sd_out && sd_oe && hs_out_n && !rx_valid, "R1 pin reset",
            {sclk, sd_out, sd_oe, hs_out_n, rx_valid}, 5'b11110);
        // R6 write to read-only bit ignored
        wr(1'b0, 8'h00);
        chk(reg_rdata == 8'h08, "R6 idle bit not writable", reg_rdata, 8'h08);

        // Sweep of edge polarity, bit order, reload and data (R2 R4 R5 R11)
        for (int p = 0; p < 2; p++)
            for (int m = 0; m < 2; m++)
                for (int n = 0; n < 3; n++)
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] cv, tb, sb;
                        cv = {3'b000, p[0], 1'b0, m[0], 2'b00};
                        tb = 8'(k * 61 + n * 83 + p * 17 + m * 5 + 15);
                        sb = 8'(tb * 7 + 99) ^ 8'(k * 36);
                        wr(1'b0, cv);
                        wr(1'b1, 8'(n));
                        xfer(tb, sb, cv, 1, n, 1, 0);
                    end

        // R2 divided count sources
        wr(1'b0, 8'h01); wr(1'b1, 8'd1);
        xfer(8'hA5, 8'h3C, 8'h01, 8, 1, 1, 0);
        wr(1'b0, 8'h16); wr(1'b1, 8'd0);
        xfer(8'h81, 8'h7E, 8'h16, 32, 0, 1, 0);

        // R3 inhibited source stalls a frame mid-way
        wr(1'b0, 8'h00); wr(1'b1, 8'd3);
        xfer(8'hC3, 8'h5A, 8'h00, 1, 3, 1, 1);
        wr(1'b1, 8'd0);

        // R7 CTS role gates the start
        hs_in_n = 1'b1;
        @(negedge clk); tx_data = 8'h96; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
        begin
            bit quiet = 1;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (!sclk) quiet = 0;
            end
            chk(quiet, "R7 no start while cts high", quiet, 1);
            chk(reg_rdata[3] == 1'b0, "R7 byte pending", reg_rdata[3], 0);
            chk(hs_out_n == 1'b1, "R7 rts pin idle in cts role", hs_out_n, 1);
        end
        hs_in_n = 1'b0;
        xfer(8'h96, 8'h69, 8'h00, 1, 0, 0, 0);

        // R9 handshake off ignores cts
        wr(1'b0, 8'h80);
        hs_in_n = 1'b1;
        xfer(8'h2D, 8'hD2, 8'h80, 1, 0, 1, 0);
        hs_in_n = 1'b0;

        // R8 RTS role
        wr(1'b0, 8'h40);
        pulse_ack();
        @(negedge clk);
        chk(hs_out_n == 1'b0, "R8 rts low when ready", hs_out_n, 0);
        xfer(8'h4B, 8'hB4, 8'h40, 1, 0, 1, 0);
        chk(hs_out_n == 1'b1, "R8 rts high until read", hs_out_n, 1);
        pulse_ack();
        chk(hs_out_n == 1'b0, "R8 rts low after read", hs_out_n, 0);

        // R10 open-drain output
        wr(1'b0, 8'h24);
        xfer(8'h0F, 8'hF0, 8'h24, 1, 0, 1, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule